// File: doc/BRIEF.md
# Tree Bitmap Longest Prefix Lookup Engine

This block resolves the longest matching route prefix for a destination address by walking a tree bitmap trie held in an external memory with a single read port. Each trie node fits in one memory word. The word holds a child-presence bitmap, a prefix-presence bitmap, the base address of the node's contiguous child block and the base address of its contiguous next-hop block. The engine consumes the address a stride at a time, starting with the most significant bits. Each level costs exactly one memory read. At each level the engine records the best match found so far without fetching anything for it.

The next-hop entry is fetched lazily. When the walk stops, the engine issues one final read for the next-hop entry of the deepest match it recorded. If no prefix matched, it issues no such read. A request is taken through a valid/ready handshake carrying the address. Memory reads go out through a valid/ready request channel, and each read comes back on a response-valid strobe after any latency. The answer leaves on a valid/ready result channel carrying a found flag and the next hop.

Back-pressure rules:
- A request is consumed on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the engine is idle.
- A memory read holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`. The response may stall for any number of cycles.
- A result holds `res_valid`, `res_found` and `res_nexthop` steady until `res_ready`.

Top module: `tbm_lookup_engine`

## Requirements
- R1: Out of reset, `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: `req_ready` is high only when no lookup is in progress. While a walk runs or a result waits, `req_ready` stays low and `req_valid` is not consumed.
- R3: A node word packs the child bitmap in bits [2^S-1:0], then the prefix bitmap (2^(S+1)-1 bits), then the child base (PTR_W bits), then the next-hop base (PTR_W bits), counting upward from bit 0. The first read goes to ROOT_ADDR, and level k uses address bits [W-1-kS -: S].
- R4: If the child bit for the slice value is set, the next node address is the child base plus the number of set child bits below that position, and the walk descends.
- R5: The prefix bit for a length-L prefix with value v sits at index 2^L-1+v, for L from 0 to S. The longest match in a node wins. Its next-hop address is the next-hop base plus the number of set prefix bits below its index.
- R6: A match in a deeper node replaces the recorded one. A node with no match keeps the shallower record.
- R7: Each visited node costs one memory read. After the walk, exactly one further read fetches the recorded next-hop entry, and its low NH_W bits are returned with `res_found`=1.
- R8: If no level matched, the result has `res_found`=0 and `res_nexthop`=0, and no next-hop read is made.
- R9: The walk visits at most W/S levels. At the last level it stops even if the child bit is set.
- R10: A memory request holds its address until accepted. Only one read is outstanding at a time, and returned data is used only on a cycle with `mem_rsp_valid`.
- R11: A result holds its value and stays valid until `res_ready`, and the engine then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request accepted |
| req_addr | input | ADDR_W | Destination address |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PTR_W | Word address to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | NODE_W | Returned memory word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_found | output | 1 | A prefix matched |
| res_nexthop | output | NH_W | Next hop of the longest match, 0 if none |

## Verification
The assertions take for granted that the memory answers each accepted read exactly once with a single `mem_rsp_valid` pulse, and never sends a response that was not asked for. The ready inputs may do anything. The bench memory model returns data a fixed number of cycles after each accepted read. It drives an all-ones word whenever the response is not valid, so any use of unqualified data would show. One scenario toggles `mem_req_ready` to stall requests, and the result handshake is held back for several cycles in another.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NODE_REQ,
    ST_NODE_WAIT,
    ST_NH_REQ,
    ST_NH_WAIT,
    ST_DONE
  } walk_state_t;

endpackage

// File: rtl/tbm_rank.sv
// Counts the set bits strictly below a position in a bitmap.
module tbm_rank #(
  parameter int WIDTH = 8,
  localparam int POS_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] bits,
  input  logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < int'(pos) && bits[i]) count = count + 1'b1;
    end
  end

endmodule

// File: rtl/tbm_node_eval.sv
// Decodes one trie node word against one address slice.
module tbm_node_eval #(
  parameter int STRIDE = 3,
  parameter int PTR_W  = 8,
  localparam int PBM_W  = 1 << STRIDE,
  localparam int FBM_W  = (1 << (STRIDE + 1)) - 1,
  localparam int NODE_W = PBM_W + FBM_W + 2 * PTR_W,
  localparam int FIDX_W = $clog2(FBM_W)
) (
  input  logic [NODE_W-1:0] node,
  input  logic [STRIDE-1:0] slice,
  output logic              has_child,
  output logic [PTR_W-1:0]  child_addr,
  output logic              match,
  output logic [PTR_W-1:0]  nh_addr
);

  localparam int PCNT_W = $clog2(PBM_W + 1);
  localparam int FCNT_W = $clog2(FBM_W + 1);

  logic [PBM_W-1:0]  child_bm;
  logic [FBM_W-1:0]  pfx_bm;
  logic [PTR_W-1:0]  child_base;
  logic [PTR_W-1:0]  nh_base;
  logic [FIDX_W-1:0] match_pos;
  logic [PCNT_W-1:0] child_rank;
  logic [FCNT_W-1:0] pfx_rank;

  assign child_bm   = node[PBM_W-1:0];
  assign pfx_bm     = node[PBM_W +: FBM_W];
  assign child_base = node[PBM_W + FBM_W +: PTR_W];
  assign nh_base    = node[PBM_W + FBM_W + PTR_W +: PTR_W];

  assign has_child  = child_bm[slice];

  // Longest prefix wins: later (longer) lengths overwrite shorter ones.
  always_comb begin
    match     = 1'b0;
    match_pos = '0;
    for (int l = 0; l <= STRIDE; l++) begin
      int idx;
      idx = (1 << l) - 1 + int'(slice >> (STRIDE - l));
      if (pfx_bm[idx]) begin
        match     = 1'b1;
        match_pos = FIDX_W'(idx);
      end
    end
  end

  tbm_rank #(.WIDTH(PBM_W)) u_child_rank (
    .bits  (child_bm),
    .pos   (slice),
    .count (child_rank)
  );

  tbm_rank #(.WIDTH(FBM_W)) u_pfx_rank (
    .bits  (pfx_bm),
    .pos   (match_pos),
    .count (pfx_rank)
  );

  assign child_addr = child_base + PTR_W'(child_rank);
  assign nh_addr    = nh_base + PTR_W'(pfx_rank);

endmodule

// File: rtl/tbm_lookup_engine.sv
module tbm_lookup_engine
  import tbm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int STRIDE    = 3,
  parameter int PTR_W     = 8,
  parameter int NH_W      = 8,
  parameter int ROOT_ADDR = 0,
  localparam int NODE_W = (1 << STRIDE) + (1 << (STRIDE + 1)) - 1 + 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PTR_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [NODE_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_found,
  output logic [NH_W-1:0]   res_nexthop
);

  localparam int LEVELS = ADDR_W / STRIDE;
  localparam int LVL_W  = $clog2(LEVELS + 1);

  walk_state_t       st;
  logic [ADDR_W-1:0] addr_sh;
  logic [LVL_W-1:0]  level;
  logic [PTR_W-1:0]  node_ptr;
  logic              best_vld;
  logic [PTR_W-1:0]  best_nh;
  logic              found_q;
  logic [NH_W-1:0]   nh_q;

  logic              ev_child;
  logic [PTR_W-1:0]  ev_child_addr;
  logic              ev_match;
  logic [PTR_W-1:0]  ev_nh_addr;
  logic              last_level;

  tbm_node_eval #(.STRIDE(STRIDE), .PTR_W(PTR_W)) u_eval (
    .node       (mem_rsp_data),
    .slice      (addr_sh[ADDR_W-1 -: STRIDE]),
    .has_child  (ev_child),
    .child_addr (ev_child_addr),
    .match      (ev_match),
    .nh_addr    (ev_nh_addr)
  );

  assign last_level = (level == LVL_W'(LEVELS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr_sh  <= '0;
      level    <= '0;
      node_ptr <= '0;
      best_vld <= 1'b0;
      best_nh  <= '0;
      found_q  <= 1'b0;
      nh_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            addr_sh  <= req_addr;
            level    <= '0;
            node_ptr <= PTR_W'(ROOT_ADDR);
            best_vld <= 1'b0;
            st       <= ST_NODE_REQ;
          end
        end
        ST_NODE_REQ: begin
          if (mem_req_ready) st <= ST_NODE_WAIT;
        end
        ST_NODE_WAIT: begin
          if (mem_rsp_valid) begin
            if (ev_match) begin
              best_vld <= 1'b1;
              best_nh  <= ev_nh_addr;
            end
            if (ev_child && !last_level) begin
              node_ptr <= ev_child_addr;
              level    <= level + 1'b1;
              addr_sh  <= addr_sh << STRIDE;
              st       <= ST_NODE_REQ;
            end else if (ev_match || best_vld) begin
              st <= ST_NH_REQ;
            end else begin
              found_q <= 1'b0;
              nh_q    <= '0;
              st      <= ST_DONE;
            end
          end
        end
        ST_NH_REQ: begin
          if (mem_req_ready) st <= ST_NH_WAIT;
        end
        ST_NH_WAIT: begin
          if (mem_rsp_valid) begin
            found_q <= 1'b1;
            nh_q    <= mem_rsp_data[NH_W-1:0];
            st      <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (res_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_NODE_REQ) || (st == ST_NH_REQ);
  assign mem_req_addr  = (st == ST_NH_REQ) ? best_nh : node_ptr;
  assign res_valid     = (st == ST_DONE);
  assign res_found     = found_q;
  assign res_nexthop   = nh_q;

endmodule

// File: rtl/tbm_lookup_chk.sv
module tbm_lookup_chk #(
  parameter int ADDR_W = 12,
  parameter int STRIDE = 3,
  parameter int PTR_W  = 8,
  parameter int NH_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PTR_W-1:0] mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_found,
  input logic [NH_W-1:0]  res_nexthop
);

  localparam int LEVELS = ADDR_W / STRIDE;
  localparam int RC_W   = $clog2(LEVELS + 3);

  logic            pending;
  logic [RC_W-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      rd_cnt  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) pending <= 1'b1;
      else if (mem_rsp_valid)             pending <= 1'b0;
      if (req_valid && req_ready)              rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  // R2
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_found) && $stable(res_nexthop)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_found) |-> (res_nexthop == '0));

  // R9
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |-> (int'(rd_cnt) < LEVELS + 1));

endmodule

bind tbm_lookup_engine tbm_lookup_chk #(
  .ADDR_W (ADDR_W),
  .STRIDE (STRIDE),
  .PTR_W  (PTR_W),
  .NH_W   (NH_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_found     (res_found),
  .res_nexthop   (res_nexthop)
);

// File: tb/tb_tbm_lookup_engine.sv
`timescale 1ns/1ps
module tb_tbm_lookup_engine;

  localparam int ADDR_W = 12;
  localparam int STRIDE = 3;
  localparam int PTR_W  = 8;
  localparam int NH_W   = 8;
  localparam int NODE_W = 8 + 15 + 2 * PTR_W;
  localparam int RD_LAT = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PTR_W-1:0]  mem_req_addr;
  logic              mem_rsp_valid;
  logic [NODE_W-1:0] mem_rsp_data;
  logic              res_valid;
  logic              res_ready = 1'b0;
  logic              res_found;
  logic [NH_W-1:0]   res_nexthop;

  int total = 0;
  int bad   = 0;

  logic [NODE_W-1:0] mem [256];
  logic              stall_mode = 1'b0;
  logic [3:0]        cyc;
  int                lat_cnt;
  logic [PTR_W-1:0]  lat_addr;
  int                nreads;

  always #2.5 clk = ~clk;

  tbm_lookup_engine #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .PTR_W(PTR_W), .NH_W(NH_W), .ROOT_ADDR(0)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_found(res_found), .res_nexthop(res_nexthop)
  );

  assign mem_req_ready = stall_mode ? cyc[1] : 1'b1;

  // Memory model: fixed latency, all-ones data when not valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc           <= '0;
      lat_cnt       <= 0;
      lat_addr      <= '0;
      nreads        <= 0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '1;
    end else begin
      cyc           <= cyc + 1'b1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '1;
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[lat_addr];
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        lat_cnt  <= RD_LAT;
        lat_addr <= mem_req_addr;
        nreads   <= nreads + 1;
      end
    end
  end

  function automatic logic [NODE_W-1:0] mk_node(input logic [7:0] cbm, input logic [14:0] pbm,
                                                input logic [7:0] cbase, input logic [7:0] nbase);
    return {nbase, cbase, pbm, cbm};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One lookup with optional result back-pressure; checks found, next hop, read count.
  task automatic lookup(input logic [ADDR_W-1:0] a, input bit exp_found,
                        input logic [NH_W-1:0] exp_nh, input int exp_reads,
                        input int hold, input string req);
    int r0;
    logic f0;
    logic [NH_W-1:0] n0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = nreads;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_addr  = ~a;
    // R2: request left valid while busy must not be taken
    chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    f0 = res_found;
    n0 = res_nexthop;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      // R11: result held until taken
      chk(res_valid && res_found == f0 && res_nexthop == n0 && !req_ready,
          "R11 hold", int'(res_nexthop), int'(n0));
    end
    chk(res_found == exp_found, {req, " found"}, int'(res_found), int'(exp_found));
    chk(res_nexthop == exp_nh, {req, " nexthop"}, int'(res_nexthop), int'(exp_nh));
    chk(nreads - r0 == exp_reads, {req, " reads"}, nreads - r0, exp_reads);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R11 release", int'(res_valid), 0);
  endtask

  task automatic load_trie();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = mk_node(8'b1000_0001, 15'h500D, 8'd1, 8'h40); // root
    mem[1] = mk_node(8'h00, 15'h0040, 8'd0, 8'h50);
    mem[2] = mk_node(8'h40, 15'h2010, 8'd3, 8'h60);
    mem[3] = mk_node(8'h02, 15'h0000, 8'd4, 8'h68);
    mem[4] = mk_node(8'hFF, 15'h0002, 8'd8, 8'h70);
    for (int i = 0; i < 5; i++) mem[8'h40 + i] = NODE_W'(8'hA0 + i);
    mem[8'h50] = NODE_W'(8'hB0);
    mem[8'h60] = NODE_W'(8'hC0);
    mem[8'h61] = NODE_W'(8'hC1);
    mem[8'h70] = NODE_W'(8'hD0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
  endtask

  task automatic t_two_level();
    // R3 R4 R5 R7: 111 then 010, deeper 01* wins
    lookup(12'hE80, 1'b1, 8'hC0, 3, 0, "R4/R5/R7 two-level");
  endtask

  task automatic t_keep_shallow();
    // R6: deeper node has no match, root 00* kept
    lookup(12'h000, 1'b1, 8'hA2, 3, 0, "R6 keep shallow");
  endtask

  task automatic t_root_only();
    // R5: root-only matches of lengths 0, 1 and 3
    lookup(12'h600, 1'b1, 8'hA0, 2, 0, "R5 default prefix");
    lookup(12'h800, 1'b1, 8'hA1, 2, 0, "R5 one-bit prefix");
    lookup(12'hA00, 1'b1, 8'hA3, 2, 0, "R5 three-bit prefix");
  endtask

  task automatic t_full_depth();
    // R9: last node has every child bit set, walk stops there
    lookup(12'hF8B, 1'b1, 8'hD0, 5, 0, "R9 full depth");
    // R6: deepest node without match keeps level-2 match
    lookup(12'hF8C, 1'b1, 8'hC1, 5, 0, "R6 full depth keep");
  endtask

  task automatic t_no_match();
    logic [NODE_W-1:0] saved;
    saved = mem[0];
    mem[0] = mk_node(8'b1000_0001, 15'h0000, 8'd1, 8'h40);
    // R8: no prefix anywhere, no next-hop read
    lookup(12'h600, 1'b0, 8'h00, 1, 0, "R8 miss root");
    lookup(12'h000, 1'b0, 8'h00, 2, 0, "R8 miss two levels");
    mem[0] = saved;
  endtask

  task automatic t_backpressure();
    stall_mode = 1'b1;
    // R10 R11: stalled memory requests and held result
    lookup(12'hE80, 1'b1, 8'hC0, 3, 4, "R10 stalled memory");
    lookup(12'hF8B, 1'b1, 8'hD0, 5, 2, "R10 stalled full depth");
    stall_mode = 1'b0;
  endtask

  initial begin
    load_trie();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_two_level();
    t_keep_shallow();
    t_root_only();
    t_full_depth();
    t_no_match();
    t_backpressure();
    t_two_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule